// File: doc/BRIEF.md
# Serial Receiver with Per-Character Error Tags

This block receives asynchronous serial characters on a single RX line and queues them for a reader. Timing comes from an oversample tick at sixteen times the bit rate. A falling edge on the line starts a character. The start bit is confirmed half a bit later, and every later bit is sampled at its centre. Characters can be 7, 8 or 9 data bits long, with an optional parity bit for the shorter lengths and one stop bit.

Each finished character is stored in a receive queue along with three tags: parity error, framing error and break. One overrun flag covers the whole queue. It is set when a character arrives to a full queue, and it stays set until the reader has drained the queue.

The read side has two modes:
- **Normal mode:** one byte is returned per character.
- **Wide mode:** each character is returned as two bytes. The first byte is the low data byte. The second byte packs the ninth data bit together with the break, framing and overrun flags.

Top module: `uart_rx_tagged`

## Requirements
- R1: After reset the queue is empty: `rd_valid`, `fifo_full` and `overrun` are low, and `rd_data` and the three tag outputs read 0.
- R2: A character starts only on a high-to-low transition of the line that is still low when the start bit is re-sampled at mid-bit (8 ticks later). A low pulse shorter than that stores nothing.
- R3: `cfg_len` selects the data length: 0 means 7 bits, 1 means 8 bits, and 2 means 9 bits. Bits arrive LSB first. In normal mode the byte returned is as follows:
  - For 7-bit characters: the 7 data bits, with bit 7 holding the received parity bit when parity is on, and 0 otherwise.
  - For 8-bit characters: the data byte.
  - For 9-bit characters: the low 8 data bits.
- R4: With `cfg_par_en` high, 7- and 8-bit characters carry a parity bit after the data. `cfg_par_odd`=0 selects even parity and 1 selects odd parity, and a mismatch sets the character's parity tag. 9-bit characters have no parity bit and are never tagged with a parity error.
- R5: A stop bit sampled low sets the character's framing tag.
- R6: A character whose data bits, parity bit (if present) and stop bit all sample low gets the break tag. Its framing tag is also set.
- R7: The queue holds `DEPTH` (384) characters in arrival order. `fifo_full` is high while it holds `DEPTH` characters.
- R8: A character that completes while the queue is full is dropped and sets `overrun`. `overrun` stays high until a read empties the queue.
- R9: With `cfg_wide` high, each character is read as two bytes:
  - First byte: data bits 7..0.
  - Second byte: bit 0 is data bit 8 (0 for 7- and 8-bit characters), bit 1 is break, bit 2 is framing error, bit 3 is the current `overrun` value, and bits 7..4 are 0.
  - The character leaves the queue only when its second byte is read.
- R10: A read request while `rd_valid` is low has no effect.
- R11: `rd_perr`, `rd_ferr` and `rd_brk` show the tags of the character at the head of the queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| os_tick | input | 1 | Oversample strobe, 16 per bit |
| rx_in | input | 1 | Serial receive line, idle high |
| cfg_len | input | 2 | Data length: 0=7, 1=8, 2=9 bits |
| cfg_par_en | input | 1 | Parity bit present (7/8-bit only) |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even |
| cfg_wide | input | 1 | Two-byte read per character |
| rd_en | input | 1 | Read strobe, consumes the shown byte |
| rd_data | output | 8 | Byte currently offered to the reader |
| rd_valid | output | 1 | Queue not empty |
| rd_perr | output | 1 | Parity tag of head character |
| rd_ferr | output | 1 | Framing tag of head character |
| rd_brk | output | 1 | Break tag of head character |
| fifo_full | output | 1 | Queue holds DEPTH characters |
| overrun | output | 1 | A character was dropped since the queue last emptied |

## Verification
The assertions check several queue properties on every cycle:
- the occupancy bound;
- that nothing is pushed while the queue is full;
- that overrun rises only from a full queue and clears only when the queue ends up empty;
- that a read of an empty queue leaves the read pointer untouched;
- that a 9-bit character is never stored with a parity tag.

Other behaviour can only be shown by the bench's scenarios, because it depends on serial timing and on values computed per character:
- data reconstruction across lengths and tick rates;
- parity polarity;
- framing and break tagging;
- glitch rejection;
- arrival order over a full queue;
- the wide-mode byte pairs.

// File: rtl/uart_rx_tagged.sv
module uart_rx_tagged #(
  parameter int DEPTH = 384
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       os_tick,
  input  logic       rx_in,
  input  logic [1:0] cfg_len,
  input  logic       cfg_par_en,
  input  logic       cfg_par_odd,
  input  logic       cfg_wide,
  input  logic       rd_en,
  output logic [7:0] rd_data,
  output logic       rd_valid,
  output logic       rd_perr,
  output logic       rd_ferr,
  output logic       rd_brk,
  output logic       fifo_full,
  output logic       overrun
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int EW = 12;

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} st_t;

  logic       rx_m, rx_s, rx_q;
  st_t        st;
  logic [3:0] tcnt;
  logic [3:0] bidx;
  logic [8:0] sh;
  logic       pbit;

  logic [3:0] nbits;
  logic       use_par, mid, frame_done;
  logic       wr_perr, wr_ferr, wr_brk;
  logic [8:0] wr_data;

  assign nbits   = (cfg_len == 2'd0) ? 4'd7 : (cfg_len == 2'd2) ? 4'd9 : 4'd8;
  assign use_par = cfg_par_en && (cfg_len != 2'd2);
  assign mid     = os_tick && (tcnt == 4'd15);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_m <= 1'b1;
      rx_s <= 1'b1;
      rx_q <= 1'b1;
    end else begin
      rx_m <= rx_in;
      rx_s <= rx_m;
      rx_q <= rx_s;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      tcnt <= '0;
      bidx <= '0;
      sh   <= '0;
      pbit <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (!rx_s && rx_q) begin
          st   <= S_START;
          tcnt <= '0;
          bidx <= '0;
          sh   <= '0;
          pbit <= 1'b0;
        end
        S_START: if (os_tick) begin
          if (tcnt == 4'd7) begin
            tcnt <= '0;
            st   <= rx_s ? S_IDLE : S_DATA;
          end else begin
            tcnt <= tcnt + 4'd1;
          end
        end
        S_DATA: if (os_tick) begin
          tcnt <= tcnt + 4'd1;
          if (mid) begin
            sh[bidx] <= rx_s;
            bidx     <= bidx + 4'd1;
            if (bidx == nbits - 4'd1) st <= use_par ? S_PAR : S_STOP;
          end
        end
        S_PAR: if (os_tick) begin
          tcnt <= tcnt + 4'd1;
          if (mid) begin
            pbit <= rx_s;
            st   <= S_STOP;
          end
        end
        S_STOP: if (os_tick) begin
          tcnt <= tcnt + 4'd1;
          if (mid) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign frame_done = (st == S_STOP) && mid;
  assign wr_perr    = use_par && (^{sh[7:0], pbit, cfg_par_odd});
  assign wr_ferr    = !rx_s;
  assign wr_brk     = !rx_s && (sh == 9'd0) && !pbit;
  assign wr_data    = (cfg_len == 2'd0 && use_par) ? {1'b0, pbit, sh[6:0]} : sh;

  logic [EW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] level;
  logic          hi_phase;
  logic          push, pop, rd_acc;
  logic [EW-1:0] head;

  assign fifo_full = (level == CW'(DEPTH));
  assign rd_valid  = (level != '0);
  assign push      = frame_done && !fifo_full;
  assign rd_acc    = rd_en && rd_valid;
  assign pop       = rd_acc && (!cfg_wide || hi_phase);
  assign head      = mem[rp];

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= {wr_brk, wr_ferr, wr_perr, wr_data};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp       <= '0;
      rp       <= '0;
      level    <= '0;
      hi_phase <= 1'b0;
      overrun  <= 1'b0;
    end else begin
      if (push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + AW'(1);
      if (pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + AW'(1);
      if (push && !pop)      level <= level + CW'(1);
      else if (pop && !push) level <= level - CW'(1);
      if (!cfg_wide)   hi_phase <= 1'b0;
      else if (rd_acc) hi_phase <= !hi_phase;
      if (frame_done && fifo_full)                        overrun <= 1'b1;
      else if (pop && !push && level == CW'(1))           overrun <= 1'b0;
    end
  end

  assign rd_data = !rd_valid ? 8'h00 :
                   (cfg_wide && hi_phase) ? {4'b0000, overrun, head[10], head[11], head[8]} :
                   head[7:0];
  assign rd_perr = rd_valid && head[9];
  assign rd_ferr = rd_valid && head[10];
  assign rd_brk  = rd_valid && head[11];
endmodule

// File: rtl/uart_rx_tagged_chk.sv
module uart_rx_tagged_chk #(
  parameter int DEPTH = 384,
  parameter int AW    = 9,
  parameter int CW    = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_en,
  input logic          rd_valid,
  input logic          fifo_full,
  input logic          overrun,
  input logic [1:0]    cfg_len,
  input logic          push,
  input logic          wr_perr,
  input logic [CW-1:0] level,
  input logic [AW-1:0] rp
);
  a_r7_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    level <= CW'(DEPTH));

  a_r7_no_push_full: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full |-> !push);

  a_r7_valid_holds: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_en |=> rd_valid);

  a_r8_ovr_rise_full: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(fifo_full));

  a_r8_ovr_clear_empty: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(overrun) |-> !rd_valid);

  a_r4_nine_no_parity: assert property (@(posedge clk) disable iff (!rst_n)
    push && cfg_len == 2'd2 |-> !wr_perr);

  a_r10_empty_read_nop: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |=> $stable(rp));
endmodule

bind uart_rx_tagged uart_rx_tagged_chk #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_valid(rd_valid),
  .fifo_full(fifo_full), .overrun(overrun), .cfg_len(cfg_len),
  .push(push), .wr_perr(wr_perr), .level(level), .rp(rp)
);

// File: tb/uart_rx_tagged_tb_top.sv
module uart_rx_tagged_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 384;
  localparam int NVEC = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic os_tick = 1'b0;
  logic rx_in = 1'b1;
  logic [1:0] cfg_len = 2'd1;
  logic cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_wide = 1'b0, rd_en = 1'b0;
  logic [7:0] rd_data;
  logic rd_valid, rd_perr, rd_ferr, rd_brk, fifo_full, overrun;

  int n_chk = 0, n_fail = 0, tick_div = 1, tick_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (tick_cnt >= tick_div - 1) begin tick_cnt <= 0; os_tick <= 1'b1; end
    else begin tick_cnt <= tick_cnt + 1; os_tick <= 1'b0; end
  end

  uart_rx_tagged #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rx_in(rx_in),
    .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_wide(cfg_wide), .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid),
    .rd_perr(rd_perr), .rd_ferr(rd_ferr), .rd_brk(rd_brk),
    .fifo_full(fifo_full), .overrun(overrun)
  );

  // {len[1:0], par_en, par_odd, bad_par, stop, pad, data[8:0]}
  localparam logic [15:0] VEC [NVEC] = '{
    {2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 9'h0A5},
    {2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 9'h035},
    {2'd0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 9'h02A},
    {2'd1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 9'h0FF},
    {2'd2, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 9'h1C3},
    {2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 9'h05A},
    {2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 9'h000},
    {2'd0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 9'h07F}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic v);
    rx_in = v;
    repeat (16 * tick_div) @(negedge clk);
  endtask

  function automatic int nb(input logic [1:0] len);
    return (len == 2'd0) ? 7 : (len == 2'd2) ? 9 : 8;
  endfunction

  function automatic logic par_val(input logic [1:0] len, input logic odd,
                                   input logic bad, input logic [8:0] d);
    logic ones = 1'b0;
    for (int i = 0; i < nb(len); i++) ones ^= d[i];
    return ones ^ odd ^ bad;
  endfunction

  task automatic send_char(input logic [1:0] len, input logic pen, input logic podd,
                           input logic bad, input logic stop, input logic [8:0] d);
    send_bit(1'b0);
    for (int i = 0; i < nb(len); i++) send_bit(d[i]);
    if (pen && len != 2'd2) send_bit(par_val(len, podd, bad, d));
    send_bit(stop);
    send_bit(1'b1);
    send_bit(1'b1);
  endtask

  task automatic pop_byte;
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] v;
    logic [7:0] eb;
    logic ep, ef, ebk, pb;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 rd_valid", {15'd0, rd_valid}, 16'd0);
    check("R1 full", {15'd0, fifo_full}, 16'd0);
    check("R1 overrun", {15'd0, overrun}, 16'd0);
    check("R1 rd_data", {8'd0, rd_data}, 16'd0);
    check("R1 tags", {13'd0, rd_perr, rd_ferr, rd_brk}, 16'd0);

    // R3 R4 R5 R6 R11: vector table
    for (int k = 0; k < NVEC; k++) begin
      v = VEC[k];
      tick_div = (k % 2 == 0) ? 1 : 3;
      cfg_len = v[15:14]; cfg_par_en = v[13]; cfg_par_odd = v[12];
      send_char(v[15:14], v[13], v[12], v[11], v[10], v[8:0]);
      pb = par_val(v[15:14], v[12], v[11], v[8:0]);
      if (v[15:14] == 2'd0) eb = {v[13] ? pb : 1'b0, v[6:0]};
      else eb = v[7:0];
      ep = v[13] && v[15:14] != 2'd2 && v[11];
      ef = !v[10];
      ebk = !v[10] && v[8:0] == 9'd0 && !(v[13] && v[15:14] != 2'd2 && pb);
      check("R3 valid", {15'd0, rd_valid}, 16'd1);
      check("R3 data", {8'd0, rd_data}, {8'd0, eb});
      check("R4 perr", {15'd0, rd_perr}, {15'd0, ep});
      check("R5 ferr", {15'd0, rd_ferr}, {15'd0, ef});
      check("R6 brk", {15'd0, rd_brk}, {15'd0, ebk});
      pop_byte();
      check("R11 drained", {15'd0, rd_valid}, 16'd0);
    end
    tick_div = 1;
    cfg_len = 2'd1; cfg_par_en = 1'b0; cfg_par_odd = 1'b0;

    // R2 glitch rejection
    rx_in = 1'b0; repeat (4) @(negedge clk); rx_in = 1'b1;
    repeat (400) @(negedge clk);
    check("R2 glitch ignored", {15'd0, rd_valid}, 16'd0);

    // R10 read on empty
    pop_byte();
    check("R10 empty read", {7'd0, rd_valid, rd_data}, 16'd0);
    send_char(2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 9'h03C);
    check("R10 next char intact", {7'd0, rd_valid, rd_data}, 16'h013C);
    pop_byte();

    // R9 wide mode pairs
    cfg_wide = 1'b1;
    cfg_len = 2'd2;
    send_char(2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 9'h1A5);
    check("R9 wide lo", {8'd0, rd_data}, 16'h00A5);
    pop_byte();
    check("R9 wide hi", {7'd0, rd_valid, rd_data}, 16'h0101);
    pop_byte();
    check("R9 pair consumed", {15'd0, rd_valid}, 16'd0);
    cfg_len = 2'd1;
    send_char(2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 9'h000);
    pop_byte();
    check("R9 R6 wide break byte", {8'd0, rd_data}, 16'h0006);
    pop_byte();
    send_char(2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 9'h055);
    check("R9 wide lo frame", {8'd0, rd_data}, 16'h0055);
    pop_byte();
    check("R9 R5 wide frame byte", {8'd0, rd_data}, 16'h0004);
    pop_byte();
    cfg_wide = 1'b0;

    // R7 R8 fill, overrun, drain
    for (int i = 0; i < DEPTH; i++)
      send_char(2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 9'(i[7:0] ^ 8'h5A));
    check("R7 full", {15'd0, fifo_full}, 16'd1);
    check("R8 no overrun yet", {15'd0, overrun}, 16'd0);
    send_char(2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 9'h0EE);
    check("R8 overrun set", {15'd0, overrun}, 16'd1);
    cfg_wide = 1'b1;
    pop_byte();
    check("R9 R8 wide overrun bit", {8'd0, rd_data}, 16'h0008);
    cfg_wide = 1'b0;
    @(negedge clk);
    for (int i = 0; i < DEPTH; i++) begin
      check("R7 order", {8'd0, rd_data}, {8'd0, i[7:0] ^ 8'h5A});
      if (i == DEPTH - 1) check("R8 overrun held", {15'd0, overrun}, 16'd1);
      pop_byte();
    end
    check("R8 overrun cleared", {15'd0, overrun}, 16'd0);
    check("R8 dropped char absent", {15'd0, rd_valid}, 16'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule